// File: doc/BRIEF.md
# Two-Slot Bundle Execute Stage

This block is the execute stage of a two-wide statically scheduled core. Each cycle it may take one 64-bit bundle made of two 32-bit instruction words and run both of them at once against a shared 32-entry register file. Each word can be an add, a subtract, an OR-immediate or a no-operation.

Both slots read all of their operands before either slot writes. A dependency between the two words of one bundle therefore sees the register value from before the bundle. A dependency that must see the new value has to be placed in a later bundle. The block holds the register file, with four read ports and two write ports. It also holds a decoder per slot, one ALU per slot and the writeback arbitration between the slots.

A combinational probe port reads any register. It is the only way the surrounding logic sees the block's state.

Top module: `pair_bundle_exec`

## Requirements
- R1: After reset every register reads 0 on the probe port.
- R2: A word with opcode bits [31:26]=0x00, shamt bits [10:6]=0 and funct bits [5:0]=0x20 writes rs+rt, modulo 2^32, to rd. The fields are rs in [25:21], rt in [20:16] and rd in [15:11].
- R3: A word with opcode 0x00, shamt 0 and funct 0x22 writes rs-rt, modulo 2^32, to rd.
- R4: A word with opcode 0x0D writes rs OR the zero-extended immediate in bits [15:0] to the register named by rt. With rs=0 this loads the immediate.
- R5: Both slots of a bundle read the register state from before the bundle. With r18=6 and r19=4, the bundle {slot0: add r18,r18,r19 ; slot1: sub r20,r18,r19} leaves r18=10 and r20=2.
- R6: Results are visible to the next bundle. The same pair issued as two bundles, each padded with a nop, leaves r18=10 and r20=6.
- R7: The all-zero word (nop) changes no register. So does any other encoding: another opcode, another funct, or a nonzero shamt on an add or subtract.
- R8: Register 0 always reads 0, and writes to it are ignored.
- R9: When both slots write the same register, the slot-1 result is kept. Slot 0 is bundle bits [31:0] and slot 1 is bits [63:32].
- R10: When bundleValid is low, the bundle lines are ignored and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bundleValid | input | 1 | Bundle lines hold a bundle to execute this cycle |
| bundle | input | 64 | Slot 1 in [63:32], slot 0 in [31:0] |
| probeAddr | input | 5 | Register to observe |
| probeData | output | DATA_W | Current value of the register named by probeAddr |

## Verification
A bundle presented with bundleValid at a rising edge updates the register file at that same edge. The probe port is combinational, so the result can be read in the half cycle that follows. The bench drives each bundle on the falling edge and drops bundleValid on the next falling edge. It then moves probeAddr and reads probeData a short settle time later, well before the next rising edge. A reference register array kept in the bench is updated with the same one-edge latency, so every comparison refers to the state after exactly one executed bundle.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
  localparam int REG_AW   = 5;
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int IMM_W    = 16;
  localparam int WORD_W   = 32;
  localparam int SLOTS    = 2;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] FN_ADD    = 6'h20;
  localparam logic [5:0] FN_SUB    = 6'h22;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} aluOp_t;

  // Strobes from a slot decoder to the datapath
  typedef struct packed {
    logic              wrEn;
    logic [REG_AW-1:0] wrAddr;
    logic [REG_AW-1:0] rsAddr;
    logic [REG_AW-1:0] rtAddr;
    aluOp_t            aluOp;
    logic              useImm;
    logic [IMM_W-1:0]  imm;
  } slotStrobe_t;
endpackage

// File: rtl/pbx_ctrl.sv
module pbx_ctrl
  import pbx_pkg::*;
(
  input  logic              slotValid,
  input  logic [WORD_W-1:0] word,
  output slotStrobe_t       strb
);
  logic [5:0] opc, fn;
  logic [4:0] shamt;

  assign opc   = word[31:26];
  assign fn    = word[5:0];
  assign shamt = word[10:6];

  always_comb begin
    strb        = '0;
    strb.rsAddr = word[25:21];
    strb.rtAddr = word[20:16];
    strb.imm    = word[15:0];
    strb.aluOp  = ALU_ADD;
    if (opc == OPC_RTYPE && shamt == 5'd0 && fn == FN_ADD) begin
      strb.wrEn   = slotValid;
      strb.wrAddr = word[15:11];
      strb.aluOp  = ALU_ADD;
    end else if (opc == OPC_RTYPE && shamt == 5'd0 && fn == FN_SUB) begin
      strb.wrEn   = slotValid;
      strb.wrAddr = word[15:11];
      strb.aluOp  = ALU_SUB;
    end else if (opc == OPC_ORI) begin
      strb.wrEn   = slotValid;
      strb.wrAddr = word[20:16];
      strb.aluOp  = ALU_OR;
      strb.useImm = 1'b1;
    end
  end
endmodule

// File: rtl/pbx_dpath.sv
module pbx_dpath
  import pbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slotStrobe_t       strb [SLOTS],
  input  logic [REG_AW-1:0] probeAddr,
  output logic [DATA_W-1:0] probeData
);
  logic [DATA_W-1:0] regs   [NUM_REGS];
  logic [DATA_W-1:0] result [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] aVal, bVal, immExt;
    assign aVal   = regs[strb[s].rsAddr];
    assign immExt = {{(DATA_W-IMM_W){1'b0}}, strb[s].imm};
    assign bVal   = strb[s].useImm ? immExt : regs[strb[s].rtAddr];
    always_comb begin
      case (strb[s].aluOp)
        ALU_SUB: result[s] = aVal - bVal;
        ALU_OR:  result[s] = aVal | bVal;
        default: result[s] = aVal + bVal;
      endcase
    end
  end

  // entry 0 is never written; the higher slot index has the last word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      for (int i = 1; i < NUM_REGS; i++) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (strb[s].wrEn && strb[s].wrAddr == REG_AW'(i)) regs[i] <= result[s];
        end
      end
    end
  end

  assign probeData = regs[probeAddr];
endmodule

// File: rtl/pair_bundle_exec.sv
module pair_bundle_exec
  import pbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bundleValid,
  input  logic [2*WORD_W-1:0] bundle,
  input  logic [REG_AW-1:0]   probeAddr,
  output logic [DATA_W-1:0]   probeData
);
  slotStrobe_t strb [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_dec
    pbx_ctrl u_ctrl (
      .slotValid (bundleValid),
      .word      (bundle[s*WORD_W +: WORD_W]),
      .strb      (strb[s])
    );
  end

  pbx_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .probeAddr (probeAddr),
    .probeData (probeData)
  );
endmodule

// File: rtl/pbx_checker.sv
module pbx_checker
  import pbx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bundleValid,
  input logic [2*WORD_W-1:0] bundle,
  input logic [REG_AW-1:0]   probeAddr,
  input logic [DATA_W-1:0]   probeData
);
  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probeAddr == '0 |-> probeData == '0);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> probeData == '0);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bundleValid && $stable(probeAddr)) |=> $stable(probeData));

  // R7
  nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bundleValid && bundle == '0) |=> (!$stable(probeAddr) || $stable(probeData)));
endmodule

bind pair_bundle_exec pbx_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pair_bundle_exec_bench.sv
`timescale 1ns/1ps
module pair_bundle_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bundleValid = 1'b0;
  logic [63:0] bundle = '0;
  logic [4:0]  probeAddr = '0;
  logic [31:0] probeData;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  pair_bundle_exec u_pair_bundle_exec (
    .clk(clk), .rst_n(rst_n), .bundleValid(bundleValid), .bundle(bundle),
    .probeAddr(probeAddr), .probeData(probeData)
  );

  function automatic logic [31:0] wAdd(input logic [4:0] d, a, b);
    return {6'h00, a, b, d, 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] wSub(input logic [4:0] d, a, b);
    return {6'h00, a, b, d, 5'd0, 6'h22};
  endfunction
  function automatic logic [31:0] wOri(input logic [4:0] d, a, input logic [15:0] imm);
    return {6'h0D, a, d, imm};
  endfunction

  // expected effect of one word on the pre-bundle state
  task automatic evalWord(input logic [31:0] w, output logic we,
                          output logic [4:0] d, output logic [31:0] v);
    logic [31:0] a, b;
    a = model[w[25:21]];
    b = model[w[20:16]];
    we = 1'b0; d = '0; v = '0;
    if (w[31:26] == 6'h00 && w[10:6] == 5'd0 && w[5:0] == 6'h20) begin
      we = 1'b1; d = w[15:11]; v = a + b;
    end else if (w[31:26] == 6'h00 && w[10:6] == 5'd0 && w[5:0] == 6'h22) begin
      we = 1'b1; d = w[15:11]; v = a - b;
    end else if (w[31:26] == 6'h0D) begin
      we = 1'b1; d = w[20:16]; v = a | {16'h0, w[15:0]};
    end
  endtask

  task automatic runBundle(input logic [31:0] w1, input logic [31:0] w0);
    logic we0, we1;
    logic [4:0] d0, d1;
    logic [31:0] v0, v1;
    evalWord(w0, we0, d0, v0);
    evalWord(w1, we1, d1, v1);
    bundle = {w1, w0};
    bundleValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bundleValid = 1'b0;
    if (we0 && d0 != 0) model[d0] = v0;
    if (we1 && d1 != 0) model[d1] = v1;
  endtask

  task automatic checkReg(input string tag, input logic [4:0] r, input logic [31:0] exp);
    probeAddr = r;
    #1;
    checks++;
    if (probeData !== exp) begin
      errors++;
      $display("FAIL %s reg %0d actual %h expected %h", tag, r, probeData, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 32; i++) checkReg("R1", 5'(i), 32'h0);

    // R4 immediate loads, both slots
    runBundle(wOri(5'd2, 5'd0, 16'hBEEF), wOri(5'd1, 5'd0, 16'h1234));
    checkReg("R4", 5'd1, 32'h0000_1234);
    checkReg("R4", 5'd2, 32'h0000_BEEF);
    runBundle(wOri(5'd4, 5'd2, 16'h0F00), wOri(5'd3, 5'd1, 16'h8001));
    checkReg("R4", 5'd3, 32'h0000_9235);
    checkReg("R4", 5'd4, 32'h0000_BFEF);

    // R2 add and R3 sub, with wraparound
    runBundle(wSub(5'd6, 5'd0, 5'd1), wAdd(5'd5, 5'd1, 5'd2));
    checkReg("R2", 5'd5, 32'h0000_D123);
    checkReg("R3", 5'd6, 32'hFFFF_EDCC);
    runBundle(wAdd(5'd7, 5'd6, 5'd1), 32'h0);
    checkReg("R2", 5'd7, 32'h0000_0000);

    // R5 same-bundle dependency reads old value
    runBundle(wOri(5'd19, 5'd0, 16'd4), wOri(5'd18, 5'd0, 16'd6));
    runBundle(wSub(5'd20, 5'd18, 5'd19), wAdd(5'd18, 5'd18, 5'd19));
    checkReg("R5", 5'd18, 32'd10);
    checkReg("R5", 5'd20, 32'd2);

    // R6 split across two bundles
    runBundle(wOri(5'd19, 5'd0, 16'd4), wOri(5'd18, 5'd0, 16'd6));
    runBundle(32'h0, wAdd(5'd18, 5'd18, 5'd19));
    runBundle(32'h0, wSub(5'd20, 5'd18, 5'd19));
    checkReg("R6", 5'd18, 32'd10);
    checkReg("R6", 5'd20, 32'd6);

    // R8 register 0 ignores writes
    runBundle(wAdd(5'd0, 5'd1, 5'd2), wOri(5'd0, 5'd0, 16'h0055));
    checkReg("R8", 5'd0, 32'h0);

    // R9 slot 1 wins on same destination
    runBundle(wOri(5'd21, 5'd0, 16'h0022), wOri(5'd21, 5'd0, 16'h0011));
    checkReg("R9", 5'd21, 32'h0000_0022);

    // R7 nop and undefined encodings
    runBundle(32'h0, 32'h0);
    for (int i = 1; i < 24; i++) checkReg("R7", 5'(i), model[i]);
    runBundle({6'h3F, 5'd0, 5'd23, 16'h00AA}, {6'h00, 5'd1, 5'd2, 5'd23, 5'd1, 6'h20});
    checkReg("R7", 5'd23, 32'h0);
    runBundle({6'h00, 5'd1, 5'd2, 5'd23, 5'd0, 6'h24}, 32'h0);
    checkReg("R7", 5'd23, 32'h0);

    // R10 bundle lines ignored without valid
    bundle = {wOri(5'd22, 5'd0, 16'h0077), wOri(5'd22, 5'd0, 16'h0077)};
    bundleValid = 1'b0;
    repeat (2) @(negedge clk);
    checkReg("R10", 5'd22, 32'h0);

    // R5/R9 sweep: every op pair, three register patterns
    for (int k1 = 0; k1 < 4; k1++) begin
      for (int k0 = 0; k0 < 4; k0++) begin
        for (int p = 0; p < 3; p++) begin
          logic [4:0] d0, a0, b0, d1, a1, b1;
          logic [31:0] w0, w1;
          case (p)
            0: begin d0 = 5'd8; a0 = 5'd1; b0 = 5'd2; d1 = 5'd9; a1 = 5'd3; b1 = 5'd4; end
            1: begin d0 = 5'd1; a0 = 5'd1; b0 = 5'd2; d1 = 5'd5; a1 = 5'd1; b1 = 5'd3; end
            default: begin d0 = 5'd6; a0 = 5'd2; b0 = 5'd7; d1 = 5'd6; a1 = 5'd6; b1 = 5'd1; end
          endcase
          case (k0)
            0: w0 = wAdd(d0, a0, b0);
            1: w0 = wSub(d0, a0, b0);
            2: w0 = wOri(d0, a0, 16'(16'h0F0 + k1 * 7 + p));
            default: w0 = 32'h0;
          endcase
          case (k1)
            0: w1 = wAdd(d1, a1, b1);
            1: w1 = wSub(d1, a1, b1);
            2: w1 = wOri(d1, a1, 16'(16'hA05 + k0 * 13 + p));
            default: w1 = 32'h0;
          endcase
          runBundle(w1, w0);
          for (int r = 1; r < 10; r++) checkReg("R5/R9 sweep", 5'(r), model[r]);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule